// File: doc/BRIEF.md
# Multicast Hash Filter

This block decides whether a received group-addressed Ethernet destination should be accepted, using an imperfect hash filter. A 4096-bit table, held as 128 words of 32 bits, holds one bit per hash bucket. For each lookup the block takes a 12-bit window out of the upper part of the 48-bit destination address. Which window it takes depends on a 2-bit mode. The upper 7 bits of that window select a table word, and the lower 5 bits select a bit within the word. The block raises `accept` one cycle after the lookup request when the filter is enabled, the address is a group address and the selected bit is set.

Software fills the table in one of two ways. It can write and read whole words through a word-indexed port. It can also hand a full multicast address to a helper port, which hashes the address with the current mode and sets the matching bit while leaving every other bit unchanged. A single clear pulse empties the whole table. The mode and the enable bit sit in a small configuration register that software can read back.

Address byte convention: byte k of the address occupies bits [8k+7:8k] of the 48-bit address bus. Byte 0 is the first byte on the wire, and bit 0 of byte 0 is the group bit.

Top module: `mc_hash_filter`

## Requirements
- R1: After a synchronous active-low reset every table word reads 0, the enable bit is 0, the mode is 0 and `accept` is 0.
- R2: A cycle with `cfg_we` high loads `cfg_mode` and `cfg_enable`, and they appear on `cfg_mode_q` and `cfg_enable_q` after that clock edge.
- R3: A cycle with `tbl_we` high replaces word `tbl_widx` with `tbl_wdata`. `tbl_rdata` always shows the current content of word `tbl_ridx` with no clock delay.
- R4: The 12-bit hash vector is address bits 47:36 in mode 0, 46:35 in mode 1, 45:34 in mode 2 and 43:32 in mode 3.
- R5: Vector bits 11:5 select the table word and vector bits 4:0 select the bit within that word.
- R6: A cycle with `set_valid` high ORs the bit of `set_addr` into the table and changes no other bit. If a word write hits the same word in the same cycle, the word becomes `tbl_wdata` with the set bit added.
- R7: A cycle with `clr_all` high zeroes all 128 words. It takes priority over a word write and a set in the same cycle, and it leaves the configuration unchanged.
- R8: `accept` is registered. It is high in the cycle after a lookup exactly when `rx_valid` was high, `rx_addr[0]` was 1, the enable bit was 1 and the selected table bit was 1.
- R9: With the enable bit at 0, or with `rx_addr[0]` at 0, `accept` stays 0 whatever the table holds.
- R10: A lookup sees the table and the enable bit as they were before that cycle's updates, and a set hashes with the mode as it was before that cycle's configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load mode and enable |
| cfg_mode | input | 2 | New hash window mode |
| cfg_enable | input | 1 | New filter enable |
| cfg_mode_q | output | 2 | Current mode |
| cfg_enable_q | output | 1 | Current enable |
| tbl_we | input | 1 | Word write strobe |
| tbl_widx | input | 7 | Word write index |
| tbl_wdata | input | 32 | Word write data |
| tbl_ridx | input | 7 | Word read index |
| tbl_rdata | output | 32 | Word read data |
| set_valid | input | 1 | Set the bit of `set_addr` |
| set_addr | input | 48 | Multicast address to add |
| clr_all | input | 1 | Zero the whole table |
| rx_valid | input | 1 | Lookup request |
| rx_addr | input | 48 | Received destination address |
| accept | output | 1 | Lookup result, one cycle later |

## Verification
Directed stimulus uses one address whose two upper bytes differ in every bit window. Setting that address in each of the four modes must land on four different words and bits, so any mistake in window selection or in the word/bit split shows up. Other directed patterns separate three cases: a word write followed by a set on the same word (OR, not overwrite), a set and a write in the same cycle, and a clear racing both of those. The group bit and the enable bit are each toggled on their own against a filled table, so that a missing qualifier gives a spurious accept. Same-cycle set plus lookup, and same-cycle set plus mode change, pin down the old-value timing. A random phase then draws lookups from a small pool of addresses that are also being set, so hits and misses both occur in every mode, and each cycle is compared against a behavioural bit-array model.

// File: rtl/mcf_pkg.sv
// Shared constants and types for the multicast hash filter.
package mcf_pkg;
    localparam int MCF_ADDR_W    = 48;
    localparam int MCF_MODE_W    = 2;
    localparam int MCF_NUM_MODES = 4;

    typedef logic [MCF_MODE_W-1:0] mcf_mode_t;

    typedef struct packed {
        logic      enable;
        mcf_mode_t mode;
    } mcf_cfg_t;

    // Lowest address bit of the hash window for each mode.
    function automatic int mcf_window_lsb(input int m);
        case (m)
            0:       return 36;
            1:       return 35;
            2:       return 34;
            default: return 32;
        endcase
    endfunction
endpackage

// File: rtl/mcf_vector_sel.sv
// Hash vector selector: picks a VEC_W-bit window from the address
// according to the mode. Assumes every window lies inside the address.
module mcf_vector_sel
    import mcf_pkg::*;
#(
    parameter int ADDR_W = MCF_ADDR_W,
    parameter int VEC_W  = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  mcf_mode_t         mode,
    output logic [VEC_W-1:0]  vec
);
    logic [VEC_W-1:0] cand [MCF_NUM_MODES];

    // One candidate window per mode.
    for (genvar m = 0; m < MCF_NUM_MODES; m++) begin : g_win
        localparam int LSB = mcf_window_lsb(m);
        assign cand[m] = addr[LSB +: VEC_W];
    end

    // Mode picks the window.
    assign vec = cand[mode];
endmodule

// File: rtl/mcf_cfg_reg.sv
// Configuration register holding the hash mode and the filter enable.
// Assumes a single writer; reset clears both fields.
module mcf_cfg_reg
    import mcf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     we,
    input  mcf_cfg_t cfg_in,
    output mcf_cfg_t cfg_q
);
    // Load on write, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= cfg_in;
        end
    end
endmodule

// File: rtl/mcf_bit_table.sv
// Hash bit table of WORDS words by WORD_W bits. Has a word write port,
// a bit-set port, a global clear, a combinational word read port and
// a combinational single-bit lookup port. Clear beats write and set;
// a write and a set on the same word merge. Reads show pre-edge state.
module mcf_bit_table #(
    parameter int WORDS  = 128,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WORDS),
    localparam int BIT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic [BIT_W-1:0]  set_bit,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  look_idx,
    input  logic [BIT_W-1:0]  look_bit,
    output logic              look_hit
);
    logic [WORD_W-1:0] words [WORDS];
    logic [WORD_W-1:0] set_mask;

    // One-hot mask of the bit being set.
    assign set_mask = WORD_W'(1) << set_bit;

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic              wr_hit;
        logic              set_hit;
        logic [WORD_W-1:0] nxt;
        logic [WORD_W-1:0] word_q;

        assign wr_hit  = wr_en  && (wr_idx  == IDX_W'(g));
        assign set_hit = set_en && (set_idx == IDX_W'(g));

        // Next word value: written data or old value, plus set bit.
        always_comb begin
            nxt = wr_hit ? wr_data : word_q;
            if (set_hit) begin
                nxt = nxt | set_mask;
            end
        end

        // Word storage with clear priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (clr) begin
                word_q <= '0;
            end else if (wr_hit || set_hit) begin
                word_q <= nxt;
            end
        end

        assign words[g] = word_q;
    end

    // Host read and lookup read.
    assign rd_data  = words[rd_idx];
    assign look_hit = words[look_idx][look_bit];
endmodule

// File: rtl/mc_hash_filter.sv
// Multicast hash filter top. Hashes received destination addresses
// into a WORDS x WORD_W bit table and registers an accept result.
// Assumes WORDS * WORD_W is a power of two covering the hash vector.
module mc_hash_filter
    import mcf_pkg::*;
#(
    parameter int WORDS  = 128,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WORDS),
    localparam int BIT_W = $clog2(WORD_W),
    localparam int VEC_W = IDX_W + BIT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [MCF_MODE_W-1:0] cfg_mode,
    input  logic                  cfg_enable,
    output logic [MCF_MODE_W-1:0] cfg_mode_q,
    output logic                  cfg_enable_q,
    input  logic                  tbl_we,
    input  logic [IDX_W-1:0]      tbl_widx,
    input  logic [WORD_W-1:0]     tbl_wdata,
    input  logic [IDX_W-1:0]      tbl_ridx,
    output logic [WORD_W-1:0]     tbl_rdata,
    input  logic                  set_valid,
    input  logic [MCF_ADDR_W-1:0] set_addr,
    input  logic                  clr_all,
    input  logic                  rx_valid,
    input  logic [MCF_ADDR_W-1:0] rx_addr,
    output logic                  accept
);
    mcf_cfg_t         cfg_in;
    mcf_cfg_t         cfg_cur;
    logic [VEC_W-1:0] set_vec;
    logic [VEC_W-1:0] rx_vec;
    logic             look_hit;
    logic             accept_q;

    assign cfg_in.enable = cfg_enable;
    assign cfg_in.mode   = cfg_mode;

    mcf_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_cur)
    );

    // Hash of the address being added by the host.
    mcf_vector_sel #(.ADDR_W(MCF_ADDR_W), .VEC_W(VEC_W)) u_set_hash (
        .addr (set_addr),
        .mode (cfg_cur.mode),
        .vec  (set_vec)
    );

    // Hash of the received destination address.
    mcf_vector_sel #(.ADDR_W(MCF_ADDR_W), .VEC_W(VEC_W)) u_rx_hash (
        .addr (rx_addr),
        .mode (cfg_cur.mode),
        .vec  (rx_vec)
    );

    mcf_bit_table #(.WORDS(WORDS), .WORD_W(WORD_W)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_all),
        .wr_en    (tbl_we),
        .wr_idx   (tbl_widx),
        .wr_data  (tbl_wdata),
        .set_en   (set_valid),
        .set_idx  (set_vec[VEC_W-1:BIT_W]),
        .set_bit  (set_vec[BIT_W-1:0]),
        .rd_idx   (tbl_ridx),
        .rd_data  (tbl_rdata),
        .look_idx (rx_vec[VEC_W-1:BIT_W]),
        .look_bit (rx_vec[BIT_W-1:0]),
        .look_hit (look_hit)
    );

    // Registered accept decision from pre-edge state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_q <= 1'b0;
        end else begin
            accept_q <= rx_valid && rx_addr[0] && cfg_cur.enable && look_hit;
        end
    end

    assign accept       = accept_q;
    assign cfg_mode_q   = cfg_cur.mode;
    assign cfg_enable_q = cfg_cur.enable;
endmodule

// File: rtl/mc_hash_filter_chk.sv
// Assertion checker for the multicast hash filter, bound to the top.
module mc_hash_filter_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [1:0]        cfg_mode,
    input logic              cfg_enable,
    input logic [1:0]        cfg_mode_q,
    input logic              cfg_enable_q,
    input logic              clr_all,
    input logic [WORD_W-1:0] tbl_rdata,
    input logic              rx_valid,
    input logic [47:0]       rx_addr,
    input logic              accept
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!accept && !cfg_enable_q && cfg_mode_q == 2'd0)); // R1

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_we) |-> (cfg_mode_q == $past(cfg_mode) && cfg_enable_q == $past(cfg_enable))); // R2

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_all) |-> (tbl_rdata == '0)); // R7

    AST_ACCEPT_NEEDS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ($past(rx_valid) && $past(rx_addr[0]))); // R8

    AST_ACCEPT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable_q |=> !accept); // R9
endmodule

bind mc_hash_filter mc_hash_filter_chk #(.WORD_W(WORD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_mode     (cfg_mode),
    .cfg_enable   (cfg_enable),
    .cfg_mode_q   (cfg_mode_q),
    .cfg_enable_q (cfg_enable_q),
    .clr_all      (clr_all),
    .tbl_rdata    (tbl_rdata),
    .rx_valid     (rx_valid),
    .rx_addr      (rx_addr),
    .accept       (accept)
);

// File: tb/mc_hash_filter_test.sv
`timescale 1ns/1ps
module mc_hash_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic        cfg_enable = 1'b0;
    logic [1:0]  cfg_mode_q;
    logic        cfg_enable_q;
    logic        tbl_we = 1'b0;
    logic [6:0]  tbl_widx = '0;
    logic [31:0] tbl_wdata = '0;
    logic [6:0]  tbl_ridx = '0;
    logic [31:0] tbl_rdata;
    logic        set_valid = 1'b0;
    logic [47:0] set_addr = '0;
    logic        clr_all = 1'b0;
    logic        rx_valid = 1'b0;
    logic [47:0] rx_addr = '0;
    logic        accept;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    mc_hash_filter uut (.*);

    // Reference model state.
    logic [4095:0] m_bits = '0;
    logic [1:0]    m_mode = '0;
    logic          m_en   = 1'b0;
    logic          m_acc  = 1'b0;

    function automatic logic [11:0] hash_of(input logic [47:0] a, input logic [1:0] m);
        logic [15:0] b5, b4, v;
        b5 = {8'd0, a[47:40]};
        b4 = {8'd0, a[39:32]};
        case (m)
            2'd0:    v = (b5 << 4) | (b4 >> 4);
            2'd1:    v = (b5 << 5) | (b4 >> 3);
            2'd2:    v = (b5 << 6) | (b4 >> 2);
            default: v = (b5 << 8) | b4;
        endcase
        return v[11:0];
    endfunction

    always @(posedge clk) begin
        logic [4095:0] nb;
        if (!rst_n) begin
            m_bits <= '0; m_mode <= '0; m_en <= 1'b0; m_acc <= 1'b0;
        end else begin
            m_acc <= rx_valid && rx_addr[0] && m_en && m_bits[hash_of(rx_addr, m_mode)];
            nb = m_bits;
            if (clr_all) nb = '0;
            else begin
                if (tbl_we) nb[int'(tbl_widx)*32 +: 32] = tbl_wdata;
                if (set_valid) nb[hash_of(set_addr, m_mode)] = 1'b1;
            end
            m_bits <= nb;
            if (cfg_we) begin m_mode <= cfg_mode; m_en <= cfg_enable; end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison with the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R8 accept", {31'd0, accept}, {31'd0, m_acc});
            check("R3 rdata", tbl_rdata, m_bits[int'(tbl_ridx)*32 +: 32]);
            check("R2 cfg", {29'd0, cfg_enable_q, cfg_mode_q}, {29'd0, m_en, m_mode});
        end
    end

    task automatic tick(); @(posedge clk); #2; endtask
    task automatic idle();
        cfg_we = 0; tbl_we = 0; set_valid = 0; clr_all = 0; rx_valid = 0;
    endtask
    task automatic rd(input int w, input logic [31:0] exp, input string req);
        tbl_ridx = 7'(w); #1; check(req, tbl_rdata, exp);
    endtask
    task automatic cfg(input logic [1:0] m, input logic e);
        cfg_we = 1; cfg_mode = m; cfg_enable = e; tick(); idle();
    endtask
    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    localparam logic [47:0] A  = 48'hABCD_0000_0001;
    localparam logic [47:0] AU = 48'hABCD_0000_0000;

    initial begin
        logic [47:0] pool [8];
        int acc_or;
        repeat (3) tick();
        rst_n = 1; #1;
        // R1 reset state
        check("R1 accept", {31'd0, accept}, 0);
        check("R1 cfg", {29'd0, cfg_enable_q, cfg_mode_q}, 0);
        rd(0, 0, "R1 word0"); rd(127, 0, "R1 word127");
        // R2 config load
        cfg(2'd2, 1'b1); #1;
        check("R2 mode", {30'd0, cfg_mode_q}, 2); check("R2 en", {31'd0, cfg_enable_q}, 1);
        // R3 word write
        tbl_we = 1; tbl_widx = 5; tbl_wdata = 32'hA5A5_0001; tick(); idle();
        rd(5, 32'hA5A5_0001, "R3 write"); rd(6, 0, "R3 neighbour");
        // R4/R5 window per mode
        clr_all = 1; tick(); idle();
        cfg(2'd0, 1'b0); set_valid = 1; set_addr = A; tick(); idle();
        rd(85, 32'h1000_0000, "R4 mode0 R5");
        cfg(2'd1, 1'b0); set_valid = 1; tick(); idle();
        rd(43, 32'h0200_0000, "R4 mode1 R5");
        cfg(2'd2, 1'b0); set_valid = 1; tick(); idle();
        rd(87, 32'h0008_0000, "R4 mode2 R5");
        cfg(2'd3, 1'b0); set_valid = 1; tick(); idle();
        rd(94, 32'h0000_2000, "R4 mode3 R5");
        rd(85, 32'h1000_0000, "R6 other bits kept");
        // R6 OR after write, and same-cycle merge
        tbl_we = 1; tbl_widx = 94; tbl_wdata = 32'h0000_0001; set_valid = 1; tick(); idle();
        rd(94, 32'h0000_2001, "R6 merge");
        tbl_we = 1; tbl_widx = 85; tbl_wdata = 32'h0000_00F0; tick(); idle();
        cfg(2'd0, 1'b0); set_valid = 1; tick(); idle();
        rd(85, 32'h1000_00F0, "R6 or");
        // R8/R9 lookups
        cfg(2'd0, 1'b1);
        rx_valid = 1; rx_addr = A; tick(); idle(); #1;
        check("R8 hit", {31'd0, accept}, 1);
        rx_valid = 1; rx_addr = AU; tick(); idle(); #1;
        check("R9 unicast", {31'd0, accept}, 0);
        rx_valid = 1; rx_addr = 48'h1234_0000_0001; tick(); idle(); #1;
        check("R8 miss", {31'd0, accept}, 0);
        cfg(2'd0, 1'b0);
        rx_valid = 1; rx_addr = A; tick(); idle(); #1;
        check("R9 disabled", {31'd0, accept}, 0);
        // R7 clear beats write and set
        clr_all = 1; tbl_we = 1; tbl_widx = 3; tbl_wdata = 32'hFFFF_FFFF; set_valid = 1; set_addr = A;
        tick(); idle();
        acc_or = 0;
        for (int w = 0; w < 128; w++) begin tbl_ridx = 7'(w); #1; acc_or |= tbl_rdata; end
        check("R7 all zero", 32'(acc_or), 0);
        check("R7 cfg kept", {30'd0, cfg_mode_q}, 0);
        // R10 same-cycle old values
        cfg(2'd0, 1'b1);
        set_valid = 1; set_addr = A; rx_valid = 1; rx_addr = A; tick(); idle(); #1;
        check("R10 lookup old table", {31'd0, accept}, 0);
        rx_valid = 1; rx_addr = A; tick(); idle(); #1;
        check("R10 then hit", {31'd0, accept}, 1);
        clr_all = 1; tick(); idle();
        cfg_we = 1; cfg_mode = 2'd3; cfg_enable = 1; set_valid = 1; set_addr = A; tick(); idle();
        rd(85, 32'h1000_0000, "R10 set old mode"); rd(94, 0, "R10 not new mode");
        // Random phase against the model
        for (int i = 0; i < 8; i++) pool[i] = {$urandom, $urandom} | 48'h1;
        for (int i = 0; i < 3000; i++) begin
            idle();
            cfg_we = ($urandom % 40) == 0; cfg_mode = 2'($urandom); cfg_enable = ($urandom % 4) != 0;
            tbl_we = ($urandom % 10) == 0; tbl_widx = 7'($urandom); tbl_wdata = $urandom;
            set_valid = ($urandom % 3) == 0; set_addr = pool[$urandom % 8];
            clr_all = ($urandom % 200) == 0;
            rx_valid = ($urandom % 2) == 0;
            rx_addr = pool[$urandom % 8] ^ {47'd0, 1'($urandom % 5 == 0)};
            tbl_ridx = 7'(hash_of(pool[$urandom % 8], cfg_mode_q) >> 5);
            tick();
        end
        idle(); tick();
        finish_run();
    end

    // Watchdog.
    initial begin
        #1_500_000;
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end
endmodule